// File: doc/BRIEF.md
# Receiver Idle Watchdog Timer

This block notices when received characters have been sitting in the receive FIFO with nothing else happening to it. It counts bit-time ticks from the receiver baud generator. Any FIFO activity starts the count again: a host read through the channel read port, a host read through the global read port, or a received character loaded into the FIFO. Once more than `LIMIT` bit times have gone by with no such activity and the FIFO still holds data, the block raises a timeout flag. The next host read clears that flag.

This lets a host service a few trailing characters that never reach the fill-level interrupt threshold. The count only advances while the FIFO holds data. After a timeout it stops at a saturation value, so each idle period produces exactly one timeout pulse. The FIFO storage and the baud generator are outside the block.

Top module: `rx_idle_watchdog`

## Requirements
- R1: After reset, `timeout_flag` and `timeout_pulse` are 0 and `idle_count` is 0.
- R2: With the FIFO non-empty and no FIFO event, `timeout_pulse` is high during the cycle of the (LIMIT+1)-th tick since the last event. `timeout_flag` reads 1 from the next cycle on. After LIMIT ticks the flag is still 0 and `idle_count` equals LIMIT.
- R3: `idle_count` advances by one only in a cycle where `bit_tick` is 1. Cycles without a tick leave it unchanged, and `timeout_pulse` is never high without `bit_tick`.
- R4: `load_char`=1 returns `idle_count` to 0 on the next cycle and leaves `timeout_flag` unchanged.
- R5: `rd_chan`=1 returns `idle_count` to 0 and clears `timeout_flag` on the next cycle.
- R6: `rd_glob`=1 has the same effect as `rd_chan`: the count restarts and the flag clears.
- R7: After a timeout, `idle_count` holds at LIMIT+1. Further ticks give no further pulse, and the flag stays set until a read.
- R8: While `fifo_empty`=1, `idle_count` is held at 0 and no timeout pulse occurs, whatever the ticks.
- R9: A FIFO event in the same cycle as the (LIMIT+1)-th tick suppresses the timeout. There is no pulse, the flag does not set, and the count restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per receiver bit time |
| rd_chan | input | 1 | Host read of the FIFO through the channel port |
| rd_glob | input | 1 | Host read of the FIFO through the global port |
| load_char | input | 1 | Received character written into the FIFO |
| fifo_empty | input | 1 | Receive FIFO holds no characters |
| idle_count | output | $clog2(LIMIT+2) | Bit times since the last FIFO event, saturating at LIMIT+1 |
| timeout_pulse | output | 1 | One-cycle strobe when the timeout fires |
| timeout_flag | output | 1 | Timeout status, set by the pulse and cleared by a read |

## Verification
A counter that misses or double-counts a tick shows up on `idle_count` on the very next cycle. It also moves the timeout pulse one tick off the (LIMIT+1)-th tick, which the bench detects at the crossing. A saturation state that is lost makes a second pulse appear on the tick after expiry. An event path that is wired wrong leaves `idle_count` non-zero, or the flag set, one cycle after the read or load. Because the bench model is compared every clock, any of these faults is reported in the cycle where the wrong value first reaches a port.

// File: rtl/rxwd_pkg.sv
package rxwd_pkg;

  typedef enum logic [1:0] {
    WD_HOLD  = 2'd0,
    WD_RUN   = 2'd1,
    WD_SPENT = 2'd2
  } wd_state_e;

  typedef struct packed {
    logic rd_any;
    logic load;
    logic restart;
  } wd_evt_t;

  // Counter width able to hold the saturation value LIMIT+1.
  function automatic int cnt_width(input int limit);
    return $clog2(limit + 2);
  endfunction

endpackage

// File: rtl/rxwd_event_detect.sv
module rxwd_event_detect
  import rxwd_pkg::*;
(
  input  logic    rd_chan,
  input  logic    rd_glob,
  input  logic    load_char,
  output wd_evt_t evt
);

  function automatic wd_evt_t classify(input logic rc, input logic rg, input logic ld);
    wd_evt_t e;
    e.rd_any  = rc | rg;
    e.load    = ld;
    e.restart = rc | rg | ld;
    return e;
  endfunction

  always_comb evt = classify(rd_chan, rd_glob, load_char);

endmodule

// File: rtl/rxwd_idle_counter.sv
module rxwd_idle_counter
  import rxwd_pkg::*;
#(
  parameter int LIMIT = 64,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          fifo_empty,
  input  logic          restart,
  output logic [CW-1:0] cnt,
  output logic          expire,
  output wd_state_e     state
);

  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);
  localparam logic [CW-1:0] SAT_V = CW'(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  wd_state_e     st_q, st_d;

  function automatic logic crossing(input logic [CW-1:0] c, input wd_state_e s, input logic tk);
    return tk && (s != WD_SPENT) && (c == LIM_V);
  endfunction

  always_comb begin
    cnt_d  = cnt_q;
    st_d   = st_q;
    expire = 1'b0;
    if (fifo_empty) begin
      cnt_d = '0;
      st_d  = WD_HOLD;
    end else if (restart) begin
      cnt_d = '0;
      st_d  = WD_RUN;
    end else if (crossing(cnt_q, st_q, bit_tick)) begin
      expire = 1'b1;
      cnt_d  = SAT_V;
      st_d   = WD_SPENT;
    end else if (st_q != WD_SPENT) begin
      st_d = WD_RUN;
      if (bit_tick) cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      st_q  <= WD_HOLD;
    end else begin
      cnt_q <= cnt_d;
      st_q  <= st_d;
    end
  end

  assign cnt   = cnt_q;
  assign state = st_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SAT_V); // R7
  AST_SPENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WD_SPENT && !restart && !fifo_empty) |=> $stable(cnt_q)); // R7
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R4
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !expire); // R8
  AST_EXPIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> bit_tick); // R3
  AST_EVENT_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !expire); // R9

endmodule

// File: rtl/rxwd_flag.sv
module rxwd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_any,
  input  logic expire,
  output logic flag
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (rd_any) flag_q <= 1'b0;
    else if (expire) flag_q <= 1'b1;
  end

  assign flag = flag_q;

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> !flag_q); // R5
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(expire)); // R2

endmodule

// File: rtl/rx_idle_watchdog.sv
module rx_idle_watchdog
  import rxwd_pkg::*;
#(
  parameter  int LIMIT = 64,
  localparam int CW    = rxwd_pkg::cnt_width(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          rd_chan,
  input  logic          rd_glob,
  input  logic          load_char,
  input  logic          fifo_empty,
  output logic [CW-1:0] idle_count,
  output logic          timeout_pulse,
  output logic          timeout_flag
);

  wd_evt_t   evt;
  logic      expire;
  wd_state_e wd_state;

  rxwd_event_detect u_evt (
    .rd_chan   (rd_chan),
    .rd_glob   (rd_glob),
    .load_char (load_char),
    .evt       (evt)
  );

  rxwd_idle_counter #(.LIMIT(LIMIT), .CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .fifo_empty (fifo_empty),
    .restart    (evt.restart),
    .cnt        (idle_count),
    .expire     (expire),
    .state      (wd_state)
  );

  rxwd_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_any (evt.rd_any),
    .expire (expire),
    .flag   (timeout_flag)
  );

  assign timeout_pulse = expire;

  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !evt.restart && !fifo_empty) |=> $stable(idle_count)); // R3
  AST_EMPTY_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |=> (wd_state == WD_HOLD)); // R8

endmodule

// File: tb/rx_idle_watchdog_test.sv
`timescale 1ns/1ps
module rx_idle_watchdog_test;
  localparam int LIMIT = 64;
  localparam int CW = $clog2(LIMIT + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 0, rd_chan = 0, rd_glob = 0, load_char = 0, fifo_empty = 1;
  logic [CW-1:0] idle_count;
  logic timeout_pulse, timeout_flag;

  int checks = 0, failures = 0, pulses = 0;
  bit emp = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model: unbounded tick count since last event
  int  m_ticks = 0;
  bit  m_flag = 1'b0;

  always #10 clk = ~clk;

  rx_idle_watchdog #(.LIMIT(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rd_chan(rd_chan),
    .rd_glob(rd_glob), .load_char(load_char), .fifo_empty(fifo_empty),
    .idle_count(idle_count), .timeout_pulse(timeout_pulse), .timeout_flag(timeout_flag)
  );

  function automatic bit model_pulse();
    return bit_tick && !fifo_empty && !(rd_chan || rd_glob || load_char) && (m_ticks == LIMIT);
  endfunction

  function automatic int model_count();
    return (m_ticks > LIMIT + 1) ? LIMIT + 1 : m_ticks;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ticks = 0;
      m_flag  = 1'b0;
    end else begin
      if (rd_chan || rd_glob) m_flag = 1'b0;
      else if (model_pulse()) m_flag = 1'b1;
      if (fifo_empty || rd_chan || rd_glob || load_char) m_ticks = 0;
      else if (bit_tick) m_ticks = m_ticks + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (timeout_pulse) pulses++;
      chk(cur_req, int'(timeout_pulse), int'(model_pulse()), "pulse");
      chk(cur_req, int'(timeout_flag), int'(m_flag), "flag");
      chk(cur_req, int'(idle_count), model_count(), "count");
    end
  end

  task automatic cyc(input bit t, input bit rc, input bit rg, input bit ld);
    bit_tick = t; rd_chan = rc; rd_glob = rg; load_char = ld; fifo_empty = emp;
    @(posedge clk); #1;
    bit_tick = 0; rd_chan = 0; rd_glob = 0; load_char = 0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      for (int j = 1; j < gap; j++) cyc(0, 0, 0, 0);
      cyc(1, 0, 0, 0);
    end
  endtask

  task automatic at_neg();
    @(negedge clk); #1;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1; emp = 1'b0;
    at_neg();
    // R1 reset state
    chk("R1", int'(timeout_flag), 0, "flag after reset");
    chk("R1", int'(idle_count), 0, "count after reset");
    chk("R1", int'(timeout_pulse), 0, "pulse after reset");

    cur_req = "R2";
    ticks(LIMIT, 3); at_neg();
    chk("R2", int'(timeout_flag), 0, "flag after LIMIT ticks");
    chk("R2", int'(idle_count), LIMIT, "count after LIMIT ticks");
    pulses = 0;
    ticks(1, 3); at_neg();
    chk("R2", int'(timeout_flag), 1, "flag after LIMIT+1 ticks");
    chk("R2", pulses, 1, "pulse at crossing");

    cur_req = "R7";
    ticks(20, 2); at_neg();
    chk("R7", int'(idle_count), LIMIT + 1, "saturated count");
    chk("R7", pulses, 1, "no second pulse");
    chk("R7", int'(timeout_flag), 1, "flag held");

    cur_req = "R5";
    cyc(0, 1, 0, 0); at_neg();
    chk("R5", int'(timeout_flag), 0, "flag after channel read");
    chk("R5", int'(idle_count), 0, "count after channel read");

    cur_req = "R6";
    ticks(LIMIT + 1, 2); at_neg();
    chk("R6", int'(timeout_flag), 1, "flag before global read");
    cyc(0, 0, 1, 0); at_neg();
    chk("R6", int'(timeout_flag), 0, "flag after global read");
    chk("R6", int'(idle_count), 0, "count after global read");

    cur_req = "R4";
    ticks(LIMIT + 11, 2); at_neg();
    cyc(0, 0, 0, 1); at_neg();
    chk("R4", int'(timeout_flag), 1, "flag kept across load");
    chk("R4", int'(idle_count), 0, "count after load");
    ticks(30, 2); at_neg();
    chk("R4", int'(idle_count), 30, "count resumes after load");

    cur_req = "R3";
    for (int k = 0; k < 50; k++) cyc(0, 0, 0, 0);
    at_neg();
    chk("R3", int'(idle_count), 30, "no advance without tick");

    cur_req = "R8";
    cyc(0, 1, 0, 0);
    emp = 1'b1;
    pulses = 0;
    ticks(100, 2); at_neg();
    chk("R8", int'(idle_count), 0, "count while empty");
    chk("R8", int'(timeout_flag), 0, "flag while empty");
    chk("R8", pulses, 0, "no pulse while empty");
    emp = 1'b0;

    cur_req = "R9";
    pulses = 0;
    ticks(LIMIT, 2);
    cyc(1, 0, 0, 1); at_neg();
    chk("R9", int'(timeout_flag), 0, "flag with load at crossing");
    chk("R9", int'(idle_count), 0, "count with load at crossing");
    ticks(LIMIT, 2);
    cyc(1, 0, 1, 0); at_neg();
    chk("R9", int'(timeout_flag), 0, "flag with read at crossing");
    chk("R9", pulses, 0, "no pulse when suppressed");
    ticks(1, 2); at_neg();
    chk("R9", int'(idle_count), 1, "count restarts after suppression");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule